// File: doc/BRIEF.md
# Dual Down-Counting Interval Timer

This peripheral sits on an APB bus and contains two identical, independent down-counters. Both run from the bus clock. Each counter has its own reload value, its own current count, its own control word and its own interrupt flag, and each drives a dedicated interrupt line. A third line combines the two. Software uses the block to raise periodic ticks, to time single intervals that stop on expiry, or to run a free-running count that it reads back.

Each counter is 32 bits wide and can run in a 16-bit size. In the 16-bit size only the low half counts down, reloads and wraps. The upper half still takes whatever software writes to the reload register and is still visible in the count. A selectable prescaler slows each counter to one step every 1, 16 or 256 clocks. A test mode allows software to drive all three interrupt pins directly from a register, so that the interrupt wiring can be checked without waiting on a counter.

Top module: `dual_down_timer`

## Requirements
- R1: After reset, for both counters: reload = 0, count = 0xFFFFFFFF, control = 0x20 (only interrupt enable set), flag = 0. Test mode is off, test bits are 0, and all three interrupt pins are low.
- R2: Register map, word aligned. Counter 0 is at base 0x00 and counter 1 is at base 0x20. Offsets within a base: reload at +0x00 (read/write), count at +0x04 (read-only), control at +0x08 (read/write, bits 6:0), clear at +0x0C (write-only, any data), raw flag at +0x10 (bit 0), masked flag at +0x14 (bit 0). Test-mode enable is at 0x40 (bit 0) and test pin bits are at 0x44 (bits 1:0). Any other address reads 0. Writes to an address with bits 1:0 not equal to 00, or to an unmapped address, change nothing.
- R3: A write to the reload register copies all 32 bits into the count on the same clock edge. This write takes priority over a count step on that edge.
- R4: Control bits are: bit 0 run enable, bit 1 one-shot, bit 2 32-bit size, bits 4:3 prescale (00 divides by 1, 01 by 16, 1x by 256), bit 5 interrupt enable, bit 6 periodic. While enabled, the count takes one step per prescaled tick. The prescaler is held at zero while the counter is disabled. The first step comes 1, 16 or 256 enabled clocks after enable. A disabled counter holds its count.
- R5: In the 16-bit size, count bits 31:16 never change except through a reload write.
- R6: A step taken with the active low part equal to zero works as follows. In one-shot mode the count holds. Otherwise, in periodic mode the active part reloads from the matching bits of the reload register. Otherwise the active part wraps to all ones. One-shot takes precedence over periodic.
- R7: The raw flag sets on a step that takes the active part from 1 to 0. A write to the clear register resets the flag. A set and a clear on the same edge leave the flag set.
- R8: Outside test mode, each counter's pin equals its raw flag ANDed with its interrupt enable, and the combined pin is the OR of the two counter pins.
- R9: With test mode on, pin 0 follows test bit 0, pin 1 follows test bit 1, and the combined pin is their OR. Counting and flags continue unaffected.
- R10: The two counters are fully independent. Any access to one counter leaves the other counter's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counting clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data (zero-wait) |
| irq_t0 | output | 1 | Counter 0 interrupt |
| irq_t1 | output | 1 | Counter 1 interrupt |
| irq_any | output | 1 | Combined interrupt |

## Verification
The assertions assume that a write strobe into a counter lasts exactly one clock. This holds because an APB access phase lasts one cycle and no wait states are inserted. They also assume that write data is stable on that edge. The stimulus drives every bus signal on the falling edge and holds a setup phase for one full cycle before each access. To bring the zero, wrap and reload cases within reach, the random reload values keep the low half small while the upper half is random. Size, mode and prescale are changed while the counters run, so the checks that the upper half holds and that a one-shot counter stays at zero are exercised across mode switches.

// File: rtl/dtim_pkg.sv
package dtim_pkg;

  typedef enum logic [1:0] {
    DIV_ONE   = 2'b00,
    DIV_MID   = 2'b01,
    DIV_FULL  = 2'b10,
    DIV_FULL2 = 2'b11
  } dtim_div_e;

  // Field order equals bit order of the control word (bit 6 .. bit 0)
  typedef struct packed {
    logic      periodic;
    logic      ie;
    dtim_div_e div;
    logic      size32;
    logic      oneshot;
    logic      enable;
  } dtim_ctrl_t;

  localparam dtim_ctrl_t CTRL_RESET = '{periodic: 1'b0, ie: 1'b1, div: DIV_ONE,
                                        size32: 1'b0, oneshot: 1'b0, enable: 1'b0};

  // Register slot indices inside one counter window (word offsets)
  localparam int unsigned SLOT_LOAD   = 0;
  localparam int unsigned SLOT_COUNT  = 1;
  localparam int unsigned SLOT_CTRL   = 2;
  localparam int unsigned SLOT_CLEAR  = 3;
  localparam int unsigned SLOT_RAW    = 4;
  localparam int unsigned SLOT_MASKED = 5;

endpackage

// File: rtl/dtim_prescale.sv
module dtim_prescale
  import dtim_pkg::*;
#(
  parameter int unsigned PRE_W   = 8,
  parameter int unsigned MID_LOG = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  dtim_div_e div_sel,
  output logic      tick
);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      pre_q <= '0;
    else if (!run)   pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    unique case (div_sel)
      DIV_ONE: tick = run;
      DIV_MID: tick = run & (&pre_q[MID_LOG-1:0]);
      default: tick = run & (&pre_q);
    endcase
  end

endmodule

// File: rtl/dtim_unit.sv
module dtim_unit
  import dtim_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned HALF_W  = 16,
  parameter int unsigned PRE_W   = 8,
  parameter int unsigned MID_LOG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_we,
  input  logic             ctrl_we,
  input  logic             clr_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] load_o,
  output logic [CNT_W-1:0] value_o,
  output dtim_ctrl_t       ctrl_o,
  output logic             raw_o,
  output logic             irq_o
);

  localparam int unsigned CTRL_W = $bits(dtim_ctrl_t);
  localparam logic [CNT_W-1:0] HALF_MASK = {{(CNT_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  logic [CNT_W-1:0] load_q, value_q, size_mask, low_bits;
  dtim_ctrl_t       ctrl_q;
  logic             raw_q;
  // Named internal events, used by the assertions below
  logic             tick, low_is_zero, low_is_one, hit_zero;

  // Next count for one step: decrement, or act on zero per mode
  function automatic logic [CNT_W-1:0] count_step(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] rel,
    input logic [CNT_W-1:0] mask,
    input dtim_ctrl_t       c
  );
    logic [CNT_W-1:0] low;
    low = cur & mask;
    if (low != '0)       return (cur & ~mask) | ((low - 1'b1) & mask);
    else if (c.oneshot)  return cur;
    else if (c.periodic) return (cur & ~mask) | (rel & mask);
    else                 return cur | mask;
  endfunction

  dtim_prescale #(.PRE_W(PRE_W), .MID_LOG(MID_LOG)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.enable),
    .div_sel (ctrl_q.div),
    .tick    (tick)
  );

  assign size_mask   = ctrl_q.size32 ? '1 : HALF_MASK;
  assign low_bits    = value_q & size_mask;
  assign low_is_zero = (low_bits == '0);
  assign low_is_one  = (low_bits == CNT_W'(1));
  assign hit_zero    = tick & ~load_we & low_is_one;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q  <= '0;
      value_q <= '1;
      ctrl_q  <= CTRL_RESET;
      raw_q   <= 1'b0;
    end else begin
      if (load_we) begin
        load_q  <= wdata;
        value_q <= wdata;
      end else if (tick) begin
        value_q <= count_step(value_q, load_q, size_mask, ctrl_q);
      end
      if (ctrl_we) ctrl_q <= dtim_ctrl_t'(wdata[CTRL_W-1:0]);
      if (hit_zero)    raw_q <= 1'b1;
      else if (clr_we) raw_q <= 1'b0;
    end
  end

  assign load_o  = load_q;
  assign value_o = value_q;
  assign ctrl_o  = ctrl_q;
  assign raw_o   = raw_q;
  assign irq_o   = raw_q & ctrl_q.ie;

  // R3: reload write lands in the count on the next state
  assert_load_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> (value_q == $past(wdata)));

  // R4: no tick and no reload write means the count holds
  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_we && !tick) |=> $stable(value_q));

  // R5: upper half untouched by counting in the 16-bit size
  assert_upper_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_we && !ctrl_q.size32) |=>
      (value_q[CNT_W-1:HALF_W] == $past(value_q[CNT_W-1:HALF_W])));

  // R6: a one-shot counter sitting at zero stays there
  assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_we && ctrl_q.oneshot && low_is_zero) |=> $stable(value_q));

  // R7: the flag only rises together with a zero count
  assert_flag_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> (value_q[HALF_W-1:0] == '0));

  // R7: a clear without a coincident expiry drops the flag
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !hit_zero) |=> !raw_q);

endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
  import dtim_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned HALF_W  = 16,
  parameter int unsigned PRE_W   = 8,
  parameter int unsigned MID_LOG = 4
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [CNT_W-1:0]  pwdata,
  output logic [CNT_W-1:0]  prdata,
  output logic              irq_t0,
  output logic              irq_t1,
  output logic              irq_any
);

  localparam int unsigned NUM_UNITS = 2;
  localparam int unsigned WORD_W    = ADDR_W - 2;
  localparam int unsigned CTRL_W    = $bits(dtim_ctrl_t);
  localparam logic [WORD_W-1:0] W_TEST_EN  = WORD_W'(16); // byte 0x40
  localparam logic [WORD_W-1:0] W_TEST_PIN = WORD_W'(17); // byte 0x44

  logic [WORD_W-1:0] word;
  logic              aligned, wr, in_units, unit_sel;
  logic [2:0]        slot;

  logic [CNT_W-1:0]     u_load  [NUM_UNITS];
  logic [CNT_W-1:0]     u_value [NUM_UNITS];
  dtim_ctrl_t           u_ctrl  [NUM_UNITS];
  logic [NUM_UNITS-1:0] u_raw, u_irq;

  logic                 test_q;
  logic [NUM_UNITS-1:0] tpin_q;

  assign word     = paddr[ADDR_W-1:2];
  assign aligned  = (paddr[1:0] == 2'b00);
  assign wr       = psel & penable & pwrite & aligned;
  assign in_units = (word[WORD_W-1:4] == '0);
  assign unit_sel = word[3];
  assign slot     = word[2:0];

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    logic hit;
    assign hit = wr & in_units & (unit_sel == g[0]);
    dtim_unit #(.CNT_W(CNT_W), .HALF_W(HALF_W), .PRE_W(PRE_W), .MID_LOG(MID_LOG)) u_cnt (
      .clk     (pclk),
      .rst_n   (presetn),
      .load_we (hit && (slot == 3'(SLOT_LOAD))),
      .ctrl_we (hit && (slot == 3'(SLOT_CTRL))),
      .clr_we  (hit && (slot == 3'(SLOT_CLEAR))),
      .wdata   (pwdata),
      .load_o  (u_load[g]),
      .value_o (u_value[g]),
      .ctrl_o  (u_ctrl[g]),
      .raw_o   (u_raw[g]),
      .irq_o   (u_irq[g])
    );
  end

  always_ff @(posedge pclk) begin
    if (!presetn) begin
      test_q <= 1'b0;
      tpin_q <= '0;
    end else begin
      if (wr && word == W_TEST_EN)  test_q <= pwdata[0];
      if (wr && word == W_TEST_PIN) tpin_q <= pwdata[NUM_UNITS-1:0];
    end
  end

  always_comb begin
    prdata = '0;
    if (aligned) begin
      if (in_units) begin
        unique case (slot)
          3'(SLOT_LOAD):   prdata = u_load[unit_sel];
          3'(SLOT_COUNT):  prdata = u_value[unit_sel];
          3'(SLOT_CTRL):   prdata = {{(CNT_W-CTRL_W){1'b0}}, u_ctrl[unit_sel]};
          3'(SLOT_RAW):    prdata = CNT_W'(u_raw[unit_sel]);
          3'(SLOT_MASKED): prdata = CNT_W'(u_irq[unit_sel]);
          default:         prdata = '0;
        endcase
      end else if (word == W_TEST_EN) begin
        prdata = CNT_W'(test_q);
      end else if (word == W_TEST_PIN) begin
        prdata = CNT_W'(tpin_q);
      end
    end
  end

  logic [NUM_UNITS-1:0] pins;
  assign pins    = test_q ? tpin_q : u_irq;
  assign irq_t0  = pins[0];
  assign irq_t1  = pins[1];
  assign irq_any = |pins;

endmodule

// File: tb/dual_down_timer_tb.sv
module dual_down_timer_tb_top;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq_t0, irq_t1, irq_any;

  int n_checks = 0;
  int n_errors = 0;

  always #2 pclk = ~pclk; // 250 MHz

  dual_down_timer dut_i (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .irq_t0(irq_t0), .irq_t1(irq_t1), .irq_any(irq_any)
  );

  // ---------------- reference model, written from the requirements ----------
  logic [31:0] m_load [2];
  logic [31:0] m_val  [2];
  logic [6:0]  m_ctrl [2];
  logic        m_raw  [2];
  logic [7:0]  m_pre  [2];
  logic        m_tst;
  logic [1:0]  m_tpin;

  function automatic logic f_tick(logic [6:0] c, logic [7:0] pre);
    if (!c[0]) return 1'b0;
    if (c[4:3] == 2'b00) return 1'b1;
    if (c[4:3] == 2'b01) return pre[3:0] == 4'hF;
    return pre == 8'hFF;
  endfunction

  function automatic logic [31:0] f_next(logic [31:0] v, logic [31:0] ld, logic [6:0] c);
    logic [15:0] lo;
    if (c[2]) begin
      if (v != 0) return v - 1;
      if (c[1])   return v;
      if (c[6])   return ld;
      return 32'hFFFF_FFFF;
    end
    lo = v[15:0];
    if (lo != 0) return {v[31:16], lo - 16'd1};
    if (c[1])    return v;
    if (c[6])    return {v[31:16], ld[15:0]};
    return {v[31:16], 16'hFFFF};
  endfunction

  function automatic logic f_at_one(logic [31:0] v, logic [6:0] c);
    return c[2] ? (v == 32'd1) : (v[15:0] == 16'd1);
  endfunction

  always @(posedge pclk) begin
    if (!presetn) begin
      for (int u = 0; u < 2; u++) begin
        m_load[u] <= '0; m_val[u] <= 32'hFFFF_FFFF; m_ctrl[u] <= 7'h20;
        m_raw[u] <= 1'b0; m_pre[u] <= '0;
      end
      m_tst <= 1'b0; m_tpin <= '0;
    end else begin
      for (int u = 0; u < 2; u++) begin
        logic wr_here, ld, tk, hz;
        wr_here = psel && penable && pwrite && paddr[1:0] == 2'b00 &&
                  paddr[11:6] == 0 && paddr[5] == u[0];
        ld = wr_here && paddr[4:2] == 3'd0;
        tk = f_tick(m_ctrl[u], m_pre[u]);
        hz = tk && !ld && f_at_one(m_val[u], m_ctrl[u]);
        m_pre[u] <= m_ctrl[u][0] ? m_pre[u] + 8'd1 : 8'd0;
        if (ld) begin m_load[u] <= pwdata; m_val[u] <= pwdata; end
        else if (tk) m_val[u] <= f_next(m_val[u], m_load[u], m_ctrl[u]);
        if (wr_here && paddr[4:2] == 3'd2) m_ctrl[u] <= pwdata[6:0];
        if (hz) m_raw[u] <= 1'b1;
        else if (wr_here && paddr[4:2] == 3'd3) m_raw[u] <= 1'b0;
      end
      if (psel && penable && pwrite && paddr == 12'h040) m_tst  <= pwdata[0];
      if (psel && penable && pwrite && paddr == 12'h044) m_tpin <= pwdata[1:0];
    end
  end

  function automatic logic [31:0] model_read(logic [11:0] a);
    int u;
    if (a[1:0] != 0) return 0;
    if (a == 12'h040) return {31'd0, m_tst};
    if (a == 12'h044) return {30'd0, m_tpin};
    if (a[11:6] != 0) return 0;
    u = a[5];
    case (a[4:2])
      3'd0: return m_load[u];
      3'd1: return m_val[u];
      3'd2: return {25'd0, m_ctrl[u]};
      3'd4: return {31'd0, m_raw[u]};
      3'd5: return {31'd0, m_raw[u] & m_ctrl[u][5]};
      default: return 0;
    endcase
  endfunction

  // ---------------- checking helpers ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk); paddr = a; pwdata = d; pwrite = 1'b1; psel = 1'b1; penable = 1'b0;
    @(negedge pclk); penable = 1'b1;
    @(negedge pclk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [11:0] a, input string tag, output logic [31:0] d);
    @(negedge pclk); paddr = a; pwrite = 1'b0; psel = 1'b1; penable = 1'b0;
    @(negedge pclk); penable = 1'b1;
    #1; d = prdata;
    check(tag, d, model_read(a));
    @(negedge pclk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic check_pins(input string tag);
    logic [1:0] e;
    @(negedge pclk); #1;
    e[0] = m_tst ? m_tpin[0] : (m_raw[0] & m_ctrl[0][5]);
    e[1] = m_tst ? m_tpin[1] : (m_raw[1] & m_ctrl[1][5]);
    check(tag, {29'd0, irq_any, irq_t1, irq_t0}, {29'd0, |e, e});
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge pclk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] d, d2;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge pclk);
    presetn = 1'b1;

    // R1: reset state
    apb_read(12'h000, "R1 load0", d);  check("R1 load0 const", d, 32'h0);
    apb_read(12'h024, "R1 count1", d); check("R1 count1 const", d, 32'hFFFF_FFFF);
    apb_read(12'h008, "R1 ctrl0", d);  check("R1 ctrl0 const", d, 32'h20);
    apb_read(12'h030, "R1 raw1", d);   check("R1 raw1 const", d, 32'h0);
    apb_read(12'h040, "R1 test", d);   check("R1 test const", d, 32'h0);
    check_pins("R1 pins");

    // R2: unmapped read, misaligned write ignored
    apb_read(12'h080, "R2 unmapped", d); check("R2 unmapped const", d, 32'h0);
    apb_write(12'h001, 32'h1234_5678);
    apb_read(12'h000, "R2 misaligned", d); check("R2 misaligned const", d, 32'h0);

    // R3: reload copies into the count while stopped
    apb_write(12'h000, 32'hABCD_0003);
    apb_read(12'h004, "R3 count0", d); check("R3 count0 const", d, 32'hABCD_0003);
    // R10: counter 1 untouched by counter 0 write
    apb_read(12'h020, "R10 load1", d); check("R10 load1 const", d, 32'h0);

    // R5 R6 R7: 16-bit free-running wrap keeps the upper half
    apb_write(12'h008, 32'h21);
    repeat (6) @(negedge pclk);
    apb_read(12'h004, "R6 wrap count0", d);
    check("R5 upper half", {16'd0, d[31:16]}, 32'h0000_ABCD);
    apb_read(12'h010, "R7 raw0 set", d); check("R7 raw0 set const", d, 32'h1);
    check_pins("R8 pin0 high");
    apb_write(12'h00C, 32'h0);
    apb_read(12'h010, "R7 raw0 cleared", d); check("R7 raw0 cleared const", d, 32'h0);

    // R6 R8: one-shot on counter 1 stops at zero
    apb_write(12'h020, 32'h0000_0004);
    apb_write(12'h028, 32'h23);
    repeat (20) @(negedge pclk);
    apb_read(12'h024, "R6 oneshot count1", d); check("R6 oneshot const", d, 32'h0);
    check_pins("R8 pin1 and combined");
    #1 check("R8 any const", {31'd0, irq_any}, 32'h1);

    // R9: test mode drives the pins
    apb_write(12'h044, 32'h1);
    apb_write(12'h040, 32'h1);
    check_pins("R9 test pin0");
    #1 check("R9 pin1 low const", {31'd0, irq_t1}, 32'h0);
    apb_write(12'h044, 32'h0);
    check_pins("R9 test none");
    apb_read(12'h030, "R9 raw1 kept", d); check("R9 raw1 const", d, 32'h1);
    apb_write(12'h040, 32'h0);
    check_pins("R9 exit");

    // R6: periodic 32-bit reload on counter 1
    apb_write(12'h020, 32'h5);
    apb_write(12'h028, 32'h65);
    repeat (13) @(negedge pclk);
    apb_read(12'h024, "R6 periodic count1", d);

    // R4: prescale by 16, then disabled hold
    apb_write(12'h000, 32'h30);
    apb_write(12'h008, 32'h2D);
    repeat (50) @(negedge pclk);
    apb_read(12'h004, "R4 div16 count0", d);
    apb_write(12'h008, 32'h24);
    apb_read(12'h004, "R4 hold a", d);
    repeat (9) @(negedge pclk);
    apb_read(12'h004, "R4 hold b", d2);
    check("R4 disabled hold", d2, d);

    // Random mix, R10 independence covered by cross-counter traffic
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [11:0] base;
      op = $urandom % 10;
      base = ($urandom % 2) ? 12'h020 : 12'h000;
      case (op)
        0: apb_write(base, {$urandom_range(65535, 0) << 16} | ($urandom % 40));
        1: apb_write(base + 12'h008, {25'd0, 6'($urandom), 1'b1});
        2: apb_write(base + 12'h00C, $urandom);
        3: apb_read(base + 12'h004, "R4 R6 random count", d);
        4: apb_read(base + 12'h010, "R7 random raw", d);
        5: apb_read(base + 12'h014, "R8 random masked", d);
        6: apb_read(base + 12'h008 - 12'h008 * ($urandom % 2), "R10 random cfg", d);
        7: begin repeat ($urandom % 20) @(negedge pclk); check_pins("R8 random pins"); end
        8: apb_write(12'h040 + 12'h004 * ($urandom % 2), $urandom % 4);
        default: begin
          apb_read(base + 12'h004, "R5 random count", d);
          apb_write(12'h008 - 12'h008 + base + 12'h008, {25'd0, 6'($urandom), 1'b0});
        end
      endcase
    end
    apb_write(12'h040, 32'h0);
    check_pins("R8 final pins");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule